// File: doc/BRIEF.md
# Iterative Shift and Rotate Unit

This block moves an 8-bit or 16-bit operand by one bit position per clock until the requested count is used up. It performs three shifts (logical left, logical right, arithmetic right) and four rotates (left and right, each either plain or through the carry flag). The count is either the fixed value one or a value taken from a count input; in the second case only the low five bits are used.

A caller drives the operand, the count, the operation code, the incoming carry flag and the width select, then pulses the start strobe for one clock. After the result is ready, the unit pulses `done_o` for one clock. At that point the result and the updated carry, overflow, sign, zero and parity flags appear on the outputs and stay there until the next operation finishes. A start strobe that arrives while an operation is still running is ignored.

Top module: `shrot_unit`

## Requirements
- R1: After reset, `result_o` is 0, all five flag outputs are 0 and `done_o` is low.
- R2: Operation code 0 shifts left and code 1 shifts right, both filling the vacated bit with 0. Code 2 shifts right and keeps the sign bit of the selected width in place. For every shift, `cf_o` receives the last bit shifted out.
- R3: Code 3 rotates left and code 4 rotates right. The bit leaving one end enters the other end and is also copied to `cf_o`. Examples: F0h rotated left once gives E1h; 3Fh rotated left four times gives F3h; F0h rotated right once gives 78h.
- R4: Code 5 rotates left through carry: the carry goes into bit 0 and the top bit goes into the carry. Code 6 rotates right through carry: the carry goes into the top bit and bit 0 goes into the carry. Examples: 88h with carry 0 rotated left gives 10h with carry 1; 10h with carry 1 rotated left gives 21h with carry 0; 10h with carry 1 rotated right gives 88h with carry 0.
- R5: When `cnt_sel_i` is 0, the count is one and `cnt_i` is ignored. When `cnt_sel_i` is 1, the count is `cnt_i[4:0]` and the upper bits of `cnt_i` are ignored.
- R6: For a count k of 1 or more, `done_o` is high for one cycle, k clocks after the clock edge that accepted the start. Until then `result_o` and the flags keep their previous values.
- R7: A count of 0, or operation code 7, finishes on the accepting edge itself. `result_o` becomes the width-masked operand, `cf_o` becomes `carry_i`, and the other flags are left unchanged.
- R8: After a shift with count 1 or more:
  - `sf_o` is the top bit of the selected width.
  - `zf_o` is 1 exactly when the result is zero.
  - `pf_o` is 1 exactly when the low 8 result bits hold an even number of ones.
- R9: A rotate leaves `sf_o`, `zf_o` and `pf_o` unchanged.
- R10: For a count of exactly 1, `of_o` is the XOR of the new top bit and the bit just below it, for every operation. For any other count, `of_o` keeps its previous value.
- R11: With `wide_i` at 0, the unit works on `operand_i[7:0]` with bit 7 as the top bit, and `result_o[15:8]` is 0. With `wide_i` at 1, it works on all 16 bits with bit 15 as the top bit.
- R12: A start strobe that arrives while an operation is running has no effect on that operation's result, its flags or its completion time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, one cycle |
| op_i | input | 3 | Operation code (0..6, 7 = no operation) |
| cnt_sel_i | input | 1 | 0: count is one; 1: count is taken from cnt_i |
| cnt_i | input | 8 | Count value (low five bits used) |
| wide_i | input | 1 | 0: 8-bit operand, 1: 16-bit operand |
| operand_i | input | 16 | Operand |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 16 | Result |
| cf_o | output | 1 | Carry flag |
| of_o | output | 1 | Overflow flag |
| sf_o | output | 1 | Sign flag |
| zf_o | output | 1 | Zero flag |
| pf_o | output | 1 | Parity flag (even parity of the low byte) |
| done_o | output | 1 | Completion pulse |

## Verification
The operands are chosen so that each one separates a pair of operations:
- F0h and 3Fh give different results for a plain rotate and a shift.
- 88h and 10h give different results for a through-carry rotate and a plain rotate, and show the carry moving between steps.
- B0h against 50h shows whether an arithmetic right shift copies the sign or fills with zero.

Counts of 0, 1, 4, 10 and 31, together with a count input whose upper bits are set, test the count masking and the completion cycle. The same counts also show when overflow is updated and when it is held.

A shift that leaves zero, followed by a rotate, shows whether the rotate touches sign, zero and parity. Byte operands with garbage in the upper bits show the width masking. A second start strobe issued in the middle of a long rotate shows whether the unit accepts a start while busy.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

   typedef enum logic [2:0] {
      OP_SHL = 3'd0,
      OP_SHR = 3'd1,
      OP_SAR = 3'd2,
      OP_ROL = 3'd3,
      OP_ROR = 3'd4,
      OP_RCL = 3'd5,
      OP_RCR = 3'd6,
      OP_NOP = 3'd7
   } shrot_op_e;

   function automatic logic op_is_shift(input shrot_op_e o);
      return (o == OP_SHL) || (o == OP_SHR) || (o == OP_SAR);
   endfunction

   function automatic logic op_is_rotate(input shrot_op_e o);
      return (o == OP_ROL) || (o == OP_ROR) || (o == OP_RCL) || (o == OP_RCR);
   endfunction

endpackage

// File: rtl/shrot_step.sv
module shrot_step
   import shrot_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8
) (
   input  logic [DATA_W-1:0] val_i,
   input  logic              carry_i,
   input  shrot_op_e         op_i,
   input  logic              wide_i,
   output logic [DATA_W-1:0] val_o,
   output logic              carry_o
);
   localparam int IW = $clog2(DATA_W);
   localparam logic [IW-1:0] HI_WIDE   = IW'(DATA_W - 1);
   localparam logic [IW-1:0] HI_NARROW = IW'(NARROW_W - 1);
   localparam logic [DATA_W-1:0] NARROW_MASK =
      {{(DATA_W - NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

   logic [IW-1:0]     hi;
   logic              out_hi, out_lo;
   logic [DATA_W-1:0] nv;

   always_comb begin
      hi     = wide_i ? HI_WIDE : HI_NARROW;
      out_hi = val_i[hi];
      out_lo = val_i[0];
      nv      = val_i;
      carry_o = carry_i;
      case (op_i)
         OP_SHL: begin nv = val_i << 1; carry_o = out_hi; end
         OP_SHR: begin nv = val_i >> 1; carry_o = out_lo; end
         OP_SAR: begin nv = val_i >> 1; nv[hi] = out_hi; carry_o = out_lo; end
         OP_ROL: begin nv = val_i << 1; nv[0] = out_hi;  carry_o = out_hi; end
         OP_ROR: begin nv = val_i >> 1; nv[hi] = out_lo; carry_o = out_lo; end
         OP_RCL: begin nv = val_i << 1; nv[0] = carry_i; carry_o = out_hi; end
         OP_RCR: begin nv = val_i >> 1; nv[hi] = carry_i; carry_o = out_lo; end
         default: begin nv = val_i; carry_o = carry_i; end
      endcase
      val_o = wide_i ? nv : (nv & NARROW_MASK);
   end
endmodule

// File: rtl/shrot_flags.sv
module shrot_flags #(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8,
   parameter int PAR_W    = 8
) (
   input  logic [DATA_W-1:0] val_i,
   input  logic              wide_i,
   output logic              sign_o,
   output logic              zero_o,
   output logic              par_even_o,
   output logic              ovf_o
);
   logic below_top;

   if (PAR_W > NARROW_W) begin : g_bad_par
      $error("PAR_W must not exceed NARROW_W");
   end

   always_comb begin
      sign_o     = wide_i ? val_i[DATA_W-1] : val_i[NARROW_W-1];
      below_top  = wide_i ? val_i[DATA_W-2] : val_i[NARROW_W-2];
      zero_o     = (val_i == '0);
      par_even_o = ~(^val_i[PAR_W-1:0]);
      ovf_o      = sign_o ^ below_top;
   end
endmodule

// File: rtl/shrot_ctrl.sv
module shrot_ctrl
   import shrot_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             cnt_sel_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  shrot_op_e        op_i,
   input  logic             wide_i,
   output logic             accept_o,
   output logic             instant_o,
   output logic             busy_o,
   output logic             last_o,
   output logic             single_o,
   output shrot_op_e        op_q_o,
   output logic             wide_q_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] steps;
   logic [CNT_W-1:0] remain_q;
   logic             busy_q, single_q, wide_q;
   shrot_op_e        op_q;

   always_comb begin
      if (op_i == OP_NOP)  steps = '0;
      else if (cnt_sel_i)  steps = cnt_i;
      else                 steps = ONE;
      accept_o  = start_i && !busy_q;
      instant_o = accept_o && (steps == '0);
      last_o    = busy_q && (remain_q == ONE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         remain_q <= '0;
         single_q <= 1'b0;
         wide_q   <= 1'b0;
         op_q     <= OP_NOP;
      end else if (accept_o) begin
         op_q     <= op_i;
         wide_q   <= wide_i;
         single_q <= (steps == ONE);
         remain_q <= steps;
         busy_q   <= (steps != '0);
      end else if (busy_q) begin
         remain_q <= remain_q - ONE;
         if (remain_q == ONE) busy_q <= 1'b0;
      end
   end

   assign busy_o   = busy_q;
   assign single_o = single_q;
   assign op_q_o   = op_q;
   assign wide_q_o = wide_q;
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
   import shrot_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8,
   parameter int CNT_IN_W = 8,
   parameter int CNT_W    = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [2:0]          op_i,
   input  logic                cnt_sel_i,
   input  logic [CNT_IN_W-1:0] cnt_i,
   input  logic                wide_i,
   input  logic [DATA_W-1:0]   operand_i,
   input  logic                carry_i,
   output logic [DATA_W-1:0]   result_o,
   output logic                cf_o,
   output logic                of_o,
   output logic                sf_o,
   output logic                zf_o,
   output logic                pf_o,
   output logic                done_o
);
   localparam logic [DATA_W-1:0] NARROW_MASK =
      {{(DATA_W - NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

   if (NARROW_W < 8 || DATA_W <= NARROW_W) begin : g_bad_width
      $error("need 8 <= NARROW_W < DATA_W");
   end
   if (CNT_W < 1 || CNT_IN_W <= CNT_W) begin : g_bad_count
      $error("need 1 <= CNT_W < CNT_IN_W");
   end

   shrot_op_e         op_in, op_q;
   logic              accept, instant, busy, last, single, wide_q;
   logic [DATA_W-1:0] in_masked, work_q, step_v;
   logic              carry_q, step_c;
   logic              f_sign, f_zero, f_par, f_ovf;
   logic              unused_cnt_hi;

   assign op_in         = shrot_op_e'(op_i);
   assign in_masked     = wide_i ? operand_i : (operand_i & NARROW_MASK);
   assign unused_cnt_hi = ^cnt_i[CNT_IN_W-1:CNT_W];

   shrot_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .cnt_sel_i (cnt_sel_i),
      .cnt_i     (cnt_i[CNT_W-1:0]),
      .op_i      (op_in),
      .wide_i    (wide_i),
      .accept_o  (accept),
      .instant_o (instant),
      .busy_o    (busy),
      .last_o    (last),
      .single_o  (single),
      .op_q_o    (op_q),
      .wide_q_o  (wide_q)
   );

   shrot_step #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_step (
      .val_i   (work_q),
      .carry_i (carry_q),
      .op_i    (op_q),
      .wide_i  (wide_q),
      .val_o   (step_v),
      .carry_o (step_c)
   );

   shrot_flags #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .PAR_W(8)) u_flags (
      .val_i      (step_v),
      .wide_i     (wide_q),
      .sign_o     (f_sign),
      .zero_o     (f_zero),
      .par_even_o (f_par),
      .ovf_o      (f_ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         work_q   <= '0;
         carry_q  <= 1'b0;
         result_o <= '0;
         cf_o     <= 1'b0;
         of_o     <= 1'b0;
         sf_o     <= 1'b0;
         zf_o     <= 1'b0;
         pf_o     <= 1'b0;
         done_o   <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (accept) begin
            work_q  <= in_masked;
            carry_q <= carry_i;
            if (instant) begin
               result_o <= in_masked;
               cf_o     <= carry_i;
               done_o   <= 1'b1;
            end
         end else if (busy) begin
            work_q  <= step_v;
            carry_q <= step_c;
            if (last) begin
               result_o <= step_v;
               cf_o     <= step_c;
               done_o   <= 1'b1;
               if (single) of_o <= f_ovf;
               if (op_is_shift(op_q)) begin
                  sf_o <= f_sign;
                  zf_o <= f_zero;
                  pf_o <= f_par;
               end
            end
         end
      end
   end
endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk
   import shrot_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] result_o,
   input logic              sf_o,
   input logic              zf_o,
   input logic              pf_o,
   input logic              done_o,
   input logic              busy_i,
   input shrot_op_e         op_q_i,
   input logic              wide_q_i
);
   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(result_o));

   assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_i);

   assert_rot_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && op_is_rotate(op_q_i)) |-> ($stable(sf_o) && $stable(zf_o) && $stable(pf_o)));

   assert_narrow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !wide_q_i) |-> (result_o[DATA_W-1:NARROW_W] == '0));

   assert_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> $stable(op_q_i));
endmodule

bind shrot_unit shrot_unit_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .result_o (result_o),
   .sf_o     (sf_o),
   .zf_o     (zf_o),
   .pf_o     (pf_o),
   .done_o   (done_o),
   .busy_i   (busy),
   .op_q_i   (op_q),
   .wide_q_i (wide_q)
);

// File: tb/shrot_unit_test.sv
module shrot_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [2:0]  op_i = 3'd0;
   logic        cnt_sel_i = 1'b0;
   logic [7:0]  cnt_i = 8'd0;
   logic        wide_i = 1'b0;
   logic [15:0] operand_i = 16'd0;
   logic        carry_i = 1'b0;
   logic [15:0] result_o;
   logic        cf_o, of_o, sf_o, zf_o, pf_o, done_o;

   int total = 0;
   int bad   = 0;

   logic [15:0] e_res = 16'd0;
   logic        e_cf = 1'b0, e_of = 1'b0, e_sf = 1'b0, e_zf = 1'b0, e_pf = 1'b0;

   always #4 clk = ~clk;

   shrot_unit uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
      .cnt_sel_i(cnt_sel_i), .cnt_i(cnt_i), .wide_i(wide_i),
      .operand_i(operand_i), .carry_i(carry_i), .result_o(result_o),
      .cf_o(cf_o), .of_o(of_o), .sf_o(sf_o), .zf_o(zf_o), .pf_o(pf_o),
      .done_o(done_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic chk_all(input string req);
      chk(req, "result", result_o, e_res);
      chk(req, "cf", cf_o, e_cf);
      chk(req, "of", of_o, e_of);
      chk(req, "sf", sf_o, e_sf);
      chk(req, "zf", zf_o, e_zf);
      chk(req, "pf", pf_o, e_pf);
   endtask

   // Behavioural reference: applies the requirement rules one bit at a time.
   task automatic run_op(input logic [2:0] op, input bit sel, input logic [7:0] cnt,
                         input bit wide, input logic [15:0] opnd, input bit cin,
                         input string req, input bit poke);
      int k, top;
      logic [15:0] v;
      logic c, hi, lo;
      logic [15:0] n_res;
      logic n_cf, n_of, n_sf, n_zf, n_pf;
      top = wide ? 15 : 7;
      k = (op == 3'd7) ? 0 : (sel ? int'(cnt & 8'h1F) : 1);
      v = wide ? opnd : (opnd & 16'h00FF);
      c = cin;
      for (int j = 0; j < k; j++) begin
         hi = v[top];
         lo = v[0];
         case (op)
            3'd0: begin v = v << 1; c = hi; end
            3'd1: begin v = v >> 1; c = lo; end
            3'd2: begin v = v >> 1; v[top] = hi; c = lo; end
            3'd3: begin v = v << 1; v[0] = hi; c = hi; end
            3'd4: begin v = v >> 1; v[top] = lo; c = lo; end
            3'd5: begin v = v << 1; v[0] = c; c = hi; end
            default: begin v = v >> 1; v[top] = c; c = lo; end
         endcase
         if (!wide) v = v & 16'h00FF;
      end
      n_res = v; n_cf = c; n_of = e_of; n_sf = e_sf; n_zf = e_zf; n_pf = e_pf;
      if (k == 1) n_of = v[top] ^ v[top-1];
      if (k > 0 && op <= 3'd2) begin
         n_sf = v[top];
         n_zf = (v == 16'd0);
         n_pf = ($countones(v[7:0]) % 2) == 0;
      end
      @(negedge clk);
      op_i = op; cnt_sel_i = sel; cnt_i = cnt; wide_i = wide;
      operand_i = opnd; carry_i = cin; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i <= k; i++) begin
         if (i == k) begin
            chk("R6", "done at count", done_o, 1);
            e_res = n_res; e_cf = n_cf; e_of = n_of; e_sf = n_sf; e_zf = n_zf; e_pf = n_pf;
            chk_all(req);
         end else begin
            chk("R6", "done early", done_o, 0);
            chk("R6", "result held", result_o, e_res);
            if (poke && i == 2) begin
               operand_i = ~opnd; op_i = 3'd0; cnt_sel_i = 1'b0; start_i = 1'b1;
            end else begin
               start_i = 1'b0;
            end
            @(negedge clk);
         end
      end
      start_i = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk_all("R1");
      chk("R1", "done", done_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "done after release", done_o, 0);

      // R3 plain rotates
      run_op(3'd3, 0, 8'd0, 0, 16'h00F0, 0, "R3", 0);
      chk("R3", "rol F0", result_o, 16'h00E1);
      run_op(3'd3, 1, 8'd4, 0, 16'h003F, 0, "R3", 0);
      chk("R3", "rol 3F by 4", result_o, 16'h00F3);
      run_op(3'd4, 0, 8'd0, 0, 16'h00F0, 1, "R3", 0);
      chk("R3", "ror F0", result_o, 16'h0078);

      // R4 through-carry rotates
      run_op(3'd5, 0, 8'd0, 0, 16'h0088, 0, "R4", 0);
      chk("R4", "rcl 88", {cf_o, result_o}, {1'b1, 16'h0010});
      run_op(3'd5, 0, 8'd0, 0, 16'h0010, 1, "R4", 0);
      chk("R4", "rcl 10", {cf_o, result_o}, {1'b0, 16'h0021});
      run_op(3'd6, 0, 8'd0, 0, 16'h0010, 1, "R4", 0);
      chk("R4", "rcr 10", {cf_o, result_o}, {1'b0, 16'h0088});

      // R2 shifts
      run_op(3'd2, 0, 8'd0, 0, 16'h00B0, 0, "R2", 0);
      chk("R2", "sar -80", result_o, 16'h00D8);
      run_op(3'd1, 0, 8'd0, 0, 16'h0050, 0, "R2", 0);
      chk("R2", "shr 80", result_o, 16'h0028);
      run_op(3'd0, 1, 8'd3, 1, 16'h8001, 0, "R2", 0);
      chk("R2", "shl word", result_o, 16'h0008);
      run_op(3'd2, 1, 8'd4, 1, 16'h8100, 0, "R2", 0);
      chk("R2", "sar word", result_o, 16'hF810);

      // R11 width masking
      run_op(3'd0, 0, 8'd0, 0, 16'hA1FF, 0, "R11", 0);
      chk("R11", "byte shl", result_o, 16'h00FE);

      // R7 zero count and no-op code
      run_op(3'd1, 1, 8'd0, 1, 16'h1234, 1, "R7", 0);
      chk("R7", "zero count", {cf_o, result_o}, {1'b1, 16'h1234});
      run_op(3'd7, 1, 8'd5, 0, 16'h5A77, 0, "R7", 0);
      chk("R7", "nop code", result_o, 16'h0077);

      // R5 count source and masking
      run_op(3'd3, 1, 8'hE3, 0, 16'h0081, 0, "R5", 0);
      chk("R5", "masked count 3", result_o, 16'h000C);
      run_op(3'd3, 0, 8'd9, 0, 16'h0081, 0, "R5", 0);
      chk("R5", "fixed count 1", result_o, 16'h0003);

      // R8 shift flags, then R9 rotate keeps them
      run_op(3'd1, 0, 8'd0, 0, 16'h0001, 0, "R8", 0);
      chk("R8", "zf/pf/sf", {zf_o, pf_o, sf_o}, 3'b110);
      run_op(3'd3, 0, 8'd0, 0, 16'h0080, 0, "R9", 0);
      chk("R9", "flags kept", {zf_o, pf_o, sf_o}, 3'b110);

      // R10 overflow
      run_op(3'd0, 0, 8'd0, 0, 16'h0040, 0, "R10", 0);
      chk("R10", "of set", of_o, 1);
      run_op(3'd0, 1, 8'd2, 0, 16'h0040, 0, "R10", 0);
      chk("R10", "of held", of_o, 1);
      run_op(3'd2, 0, 8'd0, 0, 16'h0080, 0, "R10", 0);
      chk("R10", "of clear", of_o, 0);
      run_op(3'd4, 0, 8'd0, 1, 16'h0001, 0, "R10", 0);
      chk("R10", "of ror word", of_o, 1);

      // R12 start while busy ignored
      run_op(3'd4, 1, 8'd10, 1, 16'h00FF, 0, "R12", 1);
      chk("R12", "ror word by 10", result_o, 16'h3FC0);
      @(negedge clk);
      chk("R12", "no extra done", done_o, 0);

      // long count, through-carry word rotate
      run_op(3'd5, 1, 8'd31, 1, 16'hC3A5, 1, "R4", 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule